// File: doc/BRIEF.md
# Looping Bit Pattern Player with Shaped Edges

This block plays a stored one-bit test sequence, for example a biphase-mark line signal, from on-chip storage in an endless loop. It turns each bit into eight signed sample words for a DAC, so that the analog form of every transition can be set: the slope of the edge, the overshoot and the ringing. The samples come from a small shape table. The table is indexed by the bit before, the present bit and the point within the bit, which means rising edges, falling edges and flat runs each have their own profile.

The bit rate is set by a numerically controlled oscillator. On every clock a phase word is added to an accumulator, and each carry out of the accumulator emits one sample point. As a worked case, a 12.288 MHz line rate needs about 98.3 M points per second, and a DAC clock near 100 MHz can carry that. Software writes the pattern bits and the shape table through two simple write ports. It also sets the index of the last pattern bit, which closes the loop, and raises the enable to start playback.

Top module: `edge_pattern_player`

## Requirements
- R1: While reset is high and at the first edge after it, `smp_valid` and `smp_data` are 0. Every start of playback begins at pattern index 0 and point 0, with the previous bit taken as 0.
- R2: An accumulator of `ACC_W` bits adds `step` on every enabled clock, and every carry out of it gives one sample with `smp_valid` high. When `step` divides 2^ACC_W, valid pulses come exactly 2^ACC_W/`step` cycles apart. A `step` of 0 gives no valid samples.
- R3: Every pattern bit yields exactly 8 consecutive samples, at points 0 to 7 in order.
- R4: Each sample is the shape table entry at the 5-bit index {previous bit (bit 4), current bit (bit 3), point (bits 2:0)}, shown as a signed word.
- R5: After the last point of the bit at index `pat_last`, playback goes on from index 0 with no gap. The previous bit at that join is the last bit of the loop.
- R6: A new value on `pat_last` takes effect only when the loop wraps. The loop that is running ends at the length that was latched before.
- R7: Bits written through the pattern port and entries written through the shape port are used by every sample that is formed after the write.
- R8: Lowering `en` stops valid samples from the next clock on. Raising it again restarts playback under R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Playback run enable |
| step | input | ACC_W | Phase increment per clock |
| pat_last | input | ADDR_W | Index of the final pattern bit in the loop |
| pat_we | input | 1 | Pattern write strobe |
| pat_waddr | input | ADDR_W | Pattern write index |
| pat_wbit | input | 1 | Pattern bit to store |
| shp_we | input | 1 | Shape table write strobe |
| shp_waddr | input | 5 | Shape table index {prev, cur, point} |
| shp_wdata | input | SAMP_W | Signed shape sample to store |
| smp_valid | output | 1 | A new sample is on `smp_data` |
| smp_data | output | SAMP_W | Signed DAC sample |

## Verification
The hardest case to reach is a change of loop length that is still waiting to take effect. This is a new `pat_last` that sits on the port while the shorter loop finishes, and that must not be used until the wrap. The bench starts a 4-bit loop, writes a longer length after ten samples, and then follows more than one loop. Its reference model applies the pending length only at the wrap, so a change taken early or late moves every sample after it. Restarts between steps also test that the previous bit is cleared to 0 and that the join across the wrap carries the true last bit.

// File: rtl/pb_pkg.sv
package pb_pkg;
    localparam int PT_W  = 3;
    localparam int PTS   = 1 << PT_W;
    localparam int SHP_AW = PT_W + 2;

    typedef logic [PT_W-1:0] pt_t;

    typedef struct packed {
        logic prev;
        logic cur;
        pt_t  pt;
    } shp_idx_t;

    function automatic shp_idx_t make_idx(logic prev, logic cur, pt_t pt);
        shp_idx_t r;
        r.prev = prev;
        r.cur  = cur;
        r.pt   = pt;
        return r;
    endfunction

    function automatic logic is_last_pt(pt_t pt);
        return pt == pt_t'(PTS - 1);
    endfunction
endpackage

// File: rtl/pb_nco.sv
module pb_nco #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [ACC_W-1:0] step,
    output logic             tick
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum  = {1'b0, acc} + {1'b0, step};
        tick = run & sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || !run) acc <= '0;
        else             acc <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/pb_seq.sv
module pb_seq
    import pb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              cur_bit,
    input  logic [ADDR_W-1:0] pat_last,
    output pt_t               pt_idx,
    output logic [ADDR_W-1:0] bit_addr,
    output logic              prev_bit,
    output logic [ADDR_W-1:0] act_last
);
    logic bit_end;
    logic wrap;

    always_comb begin
        bit_end = tick & is_last_pt(pt_idx);
        wrap    = bit_end & (bit_addr == act_last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pt_idx   <= '0;
            bit_addr <= '0;
            prev_bit <= 1'b0;
            act_last <= pat_last;
        end else if (tick) begin
            pt_idx <= pt_idx + pt_t'(1);
            if (bit_end) begin
                prev_bit <= cur_bit;
                if (wrap) begin
                    bit_addr <= '0;
                    act_last <= pat_last;
                end else begin
                    bit_addr <= bit_addr + ADDR_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pb_bitram.sv
module pb_bitram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DEPTH-1:0] bits;

    always_ff @(posedge clk) begin
        if (we) bits[waddr] <= wbit;
    end

    assign rbit = bits[raddr];
endmodule

// File: rtl/pb_shape_tbl.sv
module pb_shape_tbl
    import pb_pkg::*;
#(
    parameter int SAMP_W = 12
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [SHP_AW-1:0]        waddr,
    input  logic signed [SAMP_W-1:0] wdata,
    input  shp_idx_t                 raddr,
    output logic signed [SAMP_W-1:0] rdata
);
    localparam int N = 1 << SHP_AW;
    logic signed [SAMP_W-1:0] tbl [N];

    always_ff @(posedge clk) begin
        if (we) tbl[waddr] <= wdata;
    end

    assign rdata = tbl[raddr];
endmodule

// File: rtl/edge_pattern_player.sv
module edge_pattern_player
    import pb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ACC_W  = 16,
    parameter int SAMP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [ACC_W-1:0]         step,
    input  logic [ADDR_W-1:0]        pat_last,
    input  logic                     pat_we,
    input  logic [ADDR_W-1:0]        pat_waddr,
    input  logic                     pat_wbit,
    input  logic                     shp_we,
    input  logic [SHP_AW-1:0]        shp_waddr,
    input  logic signed [SAMP_W-1:0] shp_wdata,
    output logic                     smp_valid,
    output logic signed [SAMP_W-1:0] smp_data
);
    logic                     tick;
    pt_t                      pt_idx;
    logic [ADDR_W-1:0]        bit_addr;
    logic [ADDR_W-1:0]        act_last;
    logic                     prev_bit;
    logic                     cur_bit;
    shp_idx_t                 sidx;
    logic signed [SAMP_W-1:0] shp_val;

    pb_nco #(.ACC_W(ACC_W)) u_nco (
        .clk(clk), .rst(rst), .run(en), .step(step), .tick(tick)
    );

    pb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .run(en), .tick(tick), .cur_bit(cur_bit),
        .pat_last(pat_last), .pt_idx(pt_idx), .bit_addr(bit_addr),
        .prev_bit(prev_bit), .act_last(act_last)
    );

    pb_bitram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(pat_we), .waddr(pat_waddr), .wbit(pat_wbit),
        .raddr(bit_addr), .rbit(cur_bit)
    );

    assign sidx = make_idx(prev_bit, cur_bit, pt_idx);

    pb_shape_tbl #(.SAMP_W(SAMP_W)) u_tbl (
        .clk(clk), .we(shp_we), .waddr(shp_waddr), .wdata(shp_wdata),
        .raddr(sidx), .rdata(shp_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= tick;
            if (tick) smp_data <= shp_val;
        end
    end
endmodule

// File: rtl/pb_checker.sv
module pb_checker
    import pb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ACC_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [ACC_W-1:0]  step,
    input logic              smp_valid,
    input logic              tick,
    input pt_t               pt_idx,
    input logic [ADDR_W-1:0] bit_addr,
    input logic [ADDR_W-1:0] act_last
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !smp_valid); // R8
    AST_ZERO_STEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (step == '0) |=> !smp_valid); // R2
    AST_PT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !is_last_pt(pt_idx)) |=> (pt_idx == pt_t'($past(pt_idx) + pt_t'(1)))); // R3
    AST_PT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (en && tick && is_last_pt(pt_idx)) |=> (pt_idx == '0)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && tick && is_last_pt(pt_idx) && bit_addr == act_last) |=> (bit_addr == '0)); // R5
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && !(tick && is_last_pt(pt_idx) && bit_addr == act_last)) |=> $stable(act_last)); // R6
endmodule

bind edge_pattern_player pb_checker #(.ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .step(step), .smp_valid(smp_valid),
    .tick(tick), .pt_idx(pt_idx), .bit_addr(bit_addr), .act_last(act_last)
);

// File: tb/sim_edge_pattern_player.sv
module sim_edge_pattern_player;
    localparam int ADDR_W = 8;
    localparam int ACC_W  = 16;
    localparam int SAMP_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [ACC_W-1:0] step = '0;
    logic [ADDR_W-1:0] pat_last = '0;
    logic pat_we = 1'b0;
    logic [ADDR_W-1:0] pat_waddr = '0;
    logic pat_wbit = 1'b0;
    logic shp_we = 1'b0;
    logic [4:0] shp_waddr = '0;
    logic signed [SAMP_W-1:0] shp_wdata = '0;
    logic smp_valid;
    logic signed [SAMP_W-1:0] smp_data;

    always #2.5 clk = ~clk;

    edge_pattern_player #(.ADDR_W(ADDR_W), .ACC_W(ACC_W), .SAMP_W(SAMP_W)) u0 (
        .clk(clk), .rst(rst), .en(en), .step(step), .pat_last(pat_last),
        .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wbit(pat_wbit),
        .shp_we(shp_we), .shp_waddr(shp_waddr), .shp_wdata(shp_wdata),
        .smp_valid(smp_valid), .smp_data(smp_data)
    );

    int checks = 0;
    int fails  = 0;
    logic pat [256];
    int   shp [32];
    int   m_addr, m_pt, m_prev, m_last;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_bit(input int a, input logic b);
        @(negedge clk);
        pat_we = 1'b1; pat_waddr = ADDR_W'(a); pat_wbit = b;
        pat[a] = b;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic put_shape(input int a, input int v);
        @(negedge clk);
        shp_we = 1'b1; shp_waddr = 5'(a); shp_wdata = SAMP_W'(v);
        shp[a] = v;
        @(negedge clk);
        shp_we = 1'b0;
    endtask

    // start playback: model begins at index 0, point 0, previous bit 0 (R1)
    task automatic restart(input int stp);
        @(negedge clk);
        en = 1'b0;
        step = ACC_W'(stp);
        @(negedge clk);
        en = 1'b1;
        m_addr = 0; m_pt = 0; m_prev = 0; m_last = int'(pat_last);
    endtask

    // collect n samples, compare each with the model; gap>0 checks spacing
    task automatic expect_samples(input int n, input int gap, input string req);
        int last_cyc = -1;
        int cyc = 0;
        for (int k = 0; k < n; k++) begin
            int exp_v;
            int idx;
            int guard = 0;
            do begin
                @(negedge clk);
                cyc++;
                guard++;
            end while (!smp_valid && guard < 5000);
            idx = (m_prev << 4) | (int'(pat[m_addr]) << 3) | m_pt;
            exp_v = shp[idx];
            chk(smp_valid && int'(smp_data) == exp_v, req, int'(smp_data), exp_v);
            if (gap > 0 && last_cyc >= 0)
                chk(cyc - last_cyc == gap, "R2 spacing", cyc - last_cyc, gap);
            last_cyc = cyc;
            if (m_pt == 7) begin
                m_prev = int'(pat[m_addr]);
                if (m_addr == m_last) begin
                    m_addr = 0;
                    m_last = int'(pat_last);
                end else m_addr++;
                m_pt = 0;
            end else m_pt++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(smp_valid == 1'b0, "R1 valid in reset", int'(smp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(smp_valid == 1'b0 && smp_data == '0, "R1 after reset", int'(smp_data), 0);
    endtask

    task automatic t_load;
        for (int i = 0; i < 32; i++) put_shape(i, i * 97 - 1500);
        for (int i = 0; i < 16; i++) put_bit(i, logic'(((i * 5) >> 1) & 1));
    endtask

    task automatic t_basic;
        pat_last = 8'd15;
        restart(1 << 15);
        expect_samples(8 * 16 + 24, 2, "R3 R4 R5 loop");
    endtask

    task automatic t_rate;
        restart(1 << 13);
        expect_samples(20, 8, "R2 rate/8");
        restart(3 << 14);
        expect_samples(40, 0, "R4 uneven rate");
    endtask

    task automatic t_zero_step;
        int seen = 0;
        restart(0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (smp_valid) seen++;
        end
        chk(seen == 0, "R2 zero step", seen, 0);
    endtask

    task automatic t_len_change;
        pat_last = 8'd3;
        restart(1 << 15);
        expect_samples(10, 2, "R6 before change");
        pat_last = 8'd5;
        expect_samples(22 + 48 * 2, 2, "R6 pending length");
    endtask

    task automatic t_disable;
        int seen = 0;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            if (smp_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R8 disabled quiet", seen, 0);
        en = 1'b1;
        m_addr = 0; m_pt = 0; m_prev = 0; m_last = int'(pat_last);
        expect_samples(24, 2, "R8 restart from start");
    endtask

    task automatic t_rewrite;
        @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 32; i++) put_shape(i, 1800 - i * 113);
        put_bit(0, 1'b1);
        put_bit(5, ~pat[5]);
        pat_last = 8'd7;
        restart(1 << 14);
        expect_samples(8 * 8 + 16, 4, "R7 new contents");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_load();
        t_basic();
        t_rate();
        t_zero_step();
        t_len_change();
        t_disable();
        t_rewrite();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule